// File: doc/BRIEF.md
# Variable Range Register Codec

This block translates between a memory-region description and the pair of 64-bit words that program one variable address range of a memory-type table. A region is given as a page-number base, a size in pages, and an 8-bit memory type, with 4 KiB pages over a 36-bit physical address space, so page numbers are 24 bits wide. In encode mode the block first checks, one shift per clock, that the region is naturally aligned. A region that passes is packed into a base word and a mask word, and the mask word carries a valid flag. A zero size produces two all-zero words, which leaves the range switched off.

In decode mode the block takes a base word and a mask word and recovers the page base, the page count and the type in a single cycle. A mask word whose valid flag is clear reads back as a free range. A request is a single-cycle pulse on `req_i`. The result arrives with a one-cycle `done_o` pulse, and `err_o` is raised in the same cycle when an encode fails the alignment check.

Top module: `vrr_codec`

## Requirements
- R1: An encode of an aligned, nonzero region returns a base word with the page base in bits 35:12, the type in bits 7:0 and all other bits zero. It returns a mask word with (2^24 − size) mod 2^24 in bits 35:12, bit 11 (valid) set and all other bits zero. `mode_i` = 0 selects encode and 1 selects decode.
- R2: An encode with size 0 returns both words as zero with `err_o` low, and `done_o` rises one cycle after the request.
- R3: An encode is rejected, with `err_o` high in the `done_o` cycle and both words zero, exactly when one of these holds: the size is not a power of two, the base is not a multiple of the size, or base + size exceeds 2^24.
- R4: For a nonzero encode, set lo = base and hi = base + size − 1 (25 bits). Let k be the number of times both can be shifted right by one while lo is even and hi is odd. `done_o` rises k + 2 cycles after the request, and k never exceeds 25.
- R5: A decode of a mask word with bit 11 clear returns base, size and type as zero, with `err_o` low.
- R6: A decode of a mask word with bit 11 set returns the base as base-word bits 35:12, the type as base-word bits 7:0, and the size as (2^24 − mask bits 35:12) mod 2^24.
- R7: Decode results do not depend on base-word bits 11:8, on mask-word bits 10:0, or on either word's bits 63:36.
- R8: `done_o` rises one cycle after a decode request.
- R9: A request while `busy_o` is high is ignored: no extra `done_o` pulse and no change to the running encode. `done_o` is never high while `busy_o` is high.
- R10: After reset `busy_o`, `done_o` and `err_o` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pulse, accepted when not busy |
| mode_i | input | 1 | 0 = encode, 1 = decode |
| base_pn_i | input | 24 | Region base page number (encode) |
| size_pn_i | input | 24 | Region size in pages (encode) |
| type_i | input | 8 | Memory type (encode) |
| base_word_i | input | 64 | Base register word (decode) |
| mask_word_i | input | 64 | Mask register word (decode) |
| busy_o | output | 1 | Alignment check in progress |
| done_o | output | 1 | Result valid pulse |
| err_o | output | 1 | Encode rejected, valid with done_o |
| base_word_o | output | 64 | Encoded base word |
| mask_word_o | output | 64 | Encoded mask word |
| base_pn_o | output | 24 | Decoded base page number |
| size_pn_o | output | 24 | Decoded size in pages |
| type_o | output | 8 | Decoded memory type |

## Verification
Decode results and zero-size encodes are due one cycle after the request. A nonzero encode is due k + 2 cycles after the request, where k is the shift count of the alignment walk. The bench works out k on its own for every encode and counts clock edges from the request until `done_o` is seen. It compares that measured latency with the expected one, then samples the result words in that same cycle, half a period after the edge. In the cycle after each injected busy-time request it also checks that no second `done_o` pulse appears.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  typedef enum logic {OP_ENC = 1'b0, OP_DEC = 1'b1} op_e;
  typedef enum logic {CHK_IDLE = 1'b0, CHK_RUN = 1'b1} chk_st_e;
endpackage

// File: rtl/vrr_align_chk.sv
module vrr_align_chk
  import vrr_pkg::*;
#(
  parameter int PN_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [PN_W-1:0] base_i,
  input  logic [PN_W-1:0] size_i,
  output logic            busy_o,
  output logic            fin_o,
  output logic            ok_o
);
  localparam int CW    = PN_W + 1;
  localparam int CNT_W = $clog2(CW + 2);

  chk_st_e         st_q;
  logic [CW-1:0]   lo_q, hi_q;
  logic            step;
  logic [CNT_W-1:0] iter_q;

  assign busy_o = (st_q == CHK_RUN);
  assign step   = busy_o && !lo_q[0] && hi_q[0];
  assign fin_o  = busy_o && !step;
  assign ok_o   = (lo_q == hi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= CHK_IDLE;
      lo_q <= '0;
      hi_q <= '0;
    end else if (st_q == CHK_IDLE) begin
      if (start_i) begin
        lo_q <= {1'b0, base_i};
        hi_q <= {1'b0, base_i} + {1'b0, size_i} - CW'(1);
        st_q <= CHK_RUN;
      end
    end else if (step) begin
      lo_q <= lo_q >> 1;
      hi_q <= hi_q >> 1;
    end else begin
      st_q <= CHK_IDLE;
    end
  end

  // iteration counter, only for the bound check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     iter_q <= '0;
    else if (start_i && !busy_o)     iter_q <= '0;
    else if (step)                   iter_q <= iter_q + CNT_W'(1);
  end

  p_iter_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (iter_q <= CNT_W'(CW)));

  p_fin_leaves_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o);
endmodule

// File: rtl/vrr_enc.sv
module vrr_enc #(
  parameter int PN_W   = 24,
  parameter int PG_SH  = 12,
  parameter int WORD_W = 64,
  parameter int TYPE_W = 8
) (
  input  logic [PN_W-1:0]   base_i,
  input  logic [PN_W-1:0]   size_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic [WORD_W-1:0] base_word_o,
  output logic [WORD_W-1:0] mask_word_o
);
  localparam int HI_W = WORD_W - PN_W - PG_SH;

  logic [PN_W-1:0] neg_size;
  assign neg_size = '0 - size_i;

  assign base_word_o = {{HI_W{1'b0}}, base_i, {(PG_SH-TYPE_W){1'b0}}, type_i};
  // zero size clears the whole mask, valid bit included
  assign mask_word_o = (size_i == '0) ? '0 :
                       {{HI_W{1'b0}}, neg_size, 1'b1, {(PG_SH-1){1'b0}}};
endmodule

// File: rtl/vrr_dec.sv
module vrr_dec #(
  parameter int PN_W   = 24,
  parameter int PG_SH  = 12,
  parameter int WORD_W = 64,
  parameter int TYPE_W = 8
) (
  input  logic [WORD_W-1:0] base_word_i,
  input  logic [WORD_W-1:0] mask_word_i,
  output logic [PN_W-1:0]   base_o,
  output logic [PN_W-1:0]   size_o,
  output logic [TYPE_W-1:0] type_o
);
  logic            vld;
  logic [PN_W-1:0] mask_pn;

  assign vld     = mask_word_i[PG_SH-1];
  assign mask_pn = mask_word_i[PG_SH+PN_W-1:PG_SH];

  assign base_o = vld ? base_word_i[PG_SH+PN_W-1:PG_SH] : '0;
  assign size_o = vld ? ('0 - mask_pn) : '0;
  assign type_o = vld ? base_word_i[TYPE_W-1:0] : '0;
endmodule

// File: rtl/vrr_codec.sv
module vrr_codec
  import vrr_pkg::*;
#(
  parameter int PA_W   = 36,
  parameter int PG_SH  = 12,
  parameter int WORD_W = 64,
  parameter int TYPE_W = 8,
  localparam int PN_W  = PA_W - PG_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              mode_i,
  input  logic [PN_W-1:0]   base_pn_i,
  input  logic [PN_W-1:0]   size_pn_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [WORD_W-1:0] base_word_i,
  input  logic [WORD_W-1:0] mask_word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] base_word_o,
  output logic [WORD_W-1:0] mask_word_o,
  output logic [PN_W-1:0]   base_pn_o,
  output logic [PN_W-1:0]   size_pn_o,
  output logic [TYPE_W-1:0] type_o
);
  logic              accept, start, chk_busy, chk_fin, chk_ok;
  logic [PN_W-1:0]   base_q, size_q;
  logic [TYPE_W-1:0] type_q;
  logic [WORD_W-1:0] enc_base, enc_mask;
  logic [PN_W-1:0]   dec_base, dec_size;
  logic [TYPE_W-1:0] dec_type;

  assign accept = req_i && !chk_busy;
  assign start  = accept && (op_e'(mode_i) == OP_ENC) && (size_pn_i != '0);
  assign busy_o = chk_busy;

  vrr_align_chk #(.PN_W(PN_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .base_i (base_pn_i),
    .size_i (size_pn_i),
    .busy_o (chk_busy),
    .fin_o  (chk_fin),
    .ok_o   (chk_ok)
  );

  vrr_enc #(.PN_W(PN_W), .PG_SH(PG_SH), .WORD_W(WORD_W), .TYPE_W(TYPE_W)) u_enc (
    .base_i     (base_q),
    .size_i     (size_q),
    .type_i     (type_q),
    .base_word_o(enc_base),
    .mask_word_o(enc_mask)
  );

  vrr_dec #(.PN_W(PN_W), .PG_SH(PG_SH), .WORD_W(WORD_W), .TYPE_W(TYPE_W)) u_dec (
    .base_word_i(base_word_i),
    .mask_word_i(mask_word_i),
    .base_o     (dec_base),
    .size_o     (dec_size),
    .type_o     (dec_type)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      size_q      <= '0;
      type_q      <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      base_word_o <= '0;
      mask_word_o <= '0;
      base_pn_o   <= '0;
      size_pn_o   <= '0;
      type_o      <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (accept) begin
        if (op_e'(mode_i) == OP_DEC) begin
          done_o      <= 1'b1;
          base_word_o <= '0;
          mask_word_o <= '0;
          base_pn_o   <= dec_base;
          size_pn_o   <= dec_size;
          type_o      <= dec_type;
        end else if (size_pn_i == '0) begin
          done_o      <= 1'b1;
          base_word_o <= '0;
          mask_word_o <= '0;
          base_pn_o   <= '0;
          size_pn_o   <= '0;
          type_o      <= '0;
        end else begin
          base_q <= base_pn_i;
          size_q <= size_pn_i;
          type_q <= type_i;
        end
      end else if (chk_fin) begin
        done_o      <= 1'b1;
        err_o       <= !chk_ok;
        base_word_o <= chk_ok ? enc_base : '0;
        mask_word_o <= chk_ok ? enc_mask : '0;
        base_pn_o   <= '0;
        size_pn_o   <= '0;
        type_o      <= '0;
      end
    end
  end

  p_err_with_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_err_clears_words_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (base_word_o == '0 && mask_word_o == '0));

  p_enc_valid_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mask_word_o != '0) |-> mask_word_o[PG_SH-1]);

  p_busy_no_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  p_busy_needs_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
endmodule

// File: tb/vrr_codec_tb.sv
module vrr_codec_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [23:0] base_pn_i = '0, size_pn_i = '0;
  logic [7:0]  type_i = '0;
  logic [63:0] base_word_i = '0, mask_word_i = '0;
  logic        busy_o, done_o, err_o;
  logic [63:0] base_word_o, mask_word_o;
  logic [23:0] base_pn_o, size_pn_o;
  logic [7:0]  type_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vrr_codec u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .mode_i(mode_i),
    .base_pn_i(base_pn_i), .size_pn_i(size_pn_i), .type_i(type_i),
    .base_word_i(base_word_i), .mask_word_i(mask_word_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .base_word_o(base_word_o), .mask_word_o(mask_word_o),
    .base_pn_o(base_pn_o), .size_pn_o(size_pn_o), .type_o(type_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic bit exp_ok(input logic [23:0] b, input logic [23:0] s);
    logic [24:0] top;
    top = {1'b0, b} + {1'b0, s};
    return (s != 0) && ((s & (s - 24'd1)) == 0) && ((b & (s - 24'd1)) == 0) && (top <= 25'h1000000);
  endfunction

  function automatic int exp_k(input logic [23:0] b, input logic [23:0] s);
    logic [24:0] lo, hi;
    int n;
    lo = {1'b0, b};
    hi = {1'b0, b} + {1'b0, s} - 25'd1;
    n = 0;
    while (!lo[0] && hi[0]) begin
      lo = lo >> 1; hi = hi >> 1; n++;
    end
    return n;
  endfunction

  function automatic logic [63:0] exp_bw(input logic [23:0] b, input logic [7:0] t);
    return ({40'd0, b} << 12) | {56'd0, t};
  endfunction

  function automatic logic [63:0] exp_mw(input logic [23:0] s);
    logic [23:0] n;
    n = 24'd0 - s;
    return ({40'd0, n} << 12) | 64'h800;
  endfunction

  // drive one request, count edges until done
  task automatic run_op(input bit dec, input logic [23:0] b, input logic [23:0] s, input logic [7:0] t,
                        input logic [63:0] bw, input logic [63:0] mw, input bit inject, output int lat);
    @(negedge clk_i);
    mode_i = dec; base_pn_i = b; size_pn_i = s; type_i = t;
    base_word_i = bw; mask_word_i = mw; req_i = 1'b1;
    lat = 0;
    do begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      if (lat == 1 && inject) begin
        req_i = 1'b1; mode_i = 1'b1; mask_word_i = 64'h800;
      end else req_i = 1'b0;
    end while (!done_o && lat < 64);
  endtask

  task automatic do_enc(input logic [23:0] b, input logic [23:0] s, input logic [7:0] t, input bit inject);
    int lat, k;
    bit ok;
    run_op(1'b0, b, s, t, 64'd0, 64'd0, inject, lat);
    if (s == 0) begin
      check(lat == 1, "R2 latency", 64'(lat), 64'd1);
      check(!err_o && base_word_o == 0 && mask_word_o == 0, "R2 zero size words", mask_word_o, 64'd0);
    end else begin
      k = exp_k(b, s);
      ok = exp_ok(b, s);
      check(lat == k + 2 && k <= 25, "R4 encode latency", 64'(lat), 64'(k + 2));
      check(err_o == !ok, "R3 error flag", 64'(err_o), 64'(!ok));
      if (ok) begin
        check(base_word_o == exp_bw(b, t), "R1 base word", base_word_o, exp_bw(b, t));
        check(mask_word_o == exp_mw(s), "R1 mask word", mask_word_o, exp_mw(s));
      end else begin
        check(base_word_o == 0 && mask_word_o == 0, "R3 rejected words", base_word_o | mask_word_o, 64'd0);
      end
    end
    if (inject) begin
      @(negedge clk_i);
      check(!done_o, "R9 busy request ignored", 64'(done_o), 64'd0);
    end
  endtask

  task automatic do_dec(input logic [63:0] bw, input logic [63:0] mw);
    int lat;
    logic [23:0] eb, es;
    logic [7:0]  et;
    logic [23:0] rb, rs;
    logic [7:0]  rt;
    run_op(1'b1, 24'd0, 24'd0, 8'd0, bw, mw, 1'b0, lat);
    check(lat == 1 && !err_o, "R8 decode latency", 64'(lat), 64'd1);
    if (mw[11]) begin
      eb = bw[35:12]; et = bw[7:0]; es = 24'd0 - mw[35:12];
      check(base_pn_o == eb && type_o == et, "R6 decode base/type", {32'd0, base_pn_o, type_o}, {32'd0, eb, et});
      check(size_pn_o == es, "R6 decode size", 64'(size_pn_o), 64'(es));
    end else begin
      check(base_pn_o == 0 && size_pn_o == 0 && type_o == 0, "R5 free range",
            {16'd0, base_pn_o, size_pn_o}, 64'd0);
    end
    rb = base_pn_o; rs = size_pn_o; rt = type_o;
    // flip ignored bits and decode again
    run_op(1'b1, 24'd0, 24'd0, 8'd0,
           bw ^ 64'h0000_0F00 ^ {28'($urandom), 36'd0},
           mw ^ 64'h0000_07FF ^ {28'($urandom), 36'd0}, 1'b0, lat);
    check(base_pn_o == rb && size_pn_o == rs && type_o == rt, "R7 ignored bits",
          {8'd0, base_pn_o, size_pn_o, type_o}, {8'd0, rb, rs, rt});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    #(CLK_PERIOD * 3);
    check(!busy_o && !done_o && !err_o && base_word_o == 0 && mask_word_o == 0 &&
          base_pn_o == 0 && size_pn_o == 0 && type_o == 0, "R10 reset state",
          base_word_o | mask_word_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed corners
    do_enc(24'h000000, 24'h000000, 8'h06, 1'b0);   // R2 disable
    do_enc(24'h000000, 24'h800000, 8'h06, 1'b1);   // R4 longest walk, R9 inject
    do_enc(24'h800000, 24'h800000, 8'h01, 1'b0);   // R1 top half
    do_enc(24'hFFFFFF, 24'h000001, 8'h05, 1'b0);   // R1 single page at top
    do_enc(24'hFFFFF0, 24'h000020, 8'h00, 1'b0);   // R3 overflow past 2^24
    do_enc(24'h000000, 24'h000003, 8'h04, 1'b0);   // R3 not power of two
    do_enc(24'h000100, 24'h000200, 8'h04, 1'b0);   // R3 misaligned base
    do_dec(64'h0000_000F_FFFF_F006, 64'h0000_000F_FF00_0800);
    do_dec(64'h0000_0001_2345_6705, 64'h0000_000F_FFFF_F000);  // R5 free
    do_dec(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0800);  // R6 mask pn 0

    for (int i = 0; i < 40; i++) begin
      logic [23:0] s, b;
      s = 24'd1 << ($urandom % 24);
      b = 24'($urandom) & ~(s - 24'd1);
      do_enc(b, s, 8'($urandom), (i % 4) == 0);
    end
    for (int i = 0; i < 40; i++) begin
      do_enc(24'($urandom), 24'($urandom % 64), 8'($urandom), 1'b0);
    end
    for (int i = 0; i < 40; i++) begin
      logic [63:0] bw, mw;
      bw = {$urandom, $urandom};
      mw = {$urandom, $urandom};
      mw[11] = (i % 2) == 0;
      do_dec(bw, mw);
    end

    summary();
    $finish;
  end
endmodule